// File: doc/BRIEF.md
# Ordered Store Buffer with Read Bypass Drain

This block stands between one processor core's memory request port and the packet injection port toward the system interconnect, and it reproduces the write-ordering behaviour of a total-store-order core. Stores are taken in at once and parked in a small first-in first-out buffer of address/data entries. Nothing reaches the interconnect for them until something forces it out.

A load compares its address against every parked store. If no parked store matches, the load goes straight out as a read packet. If some stores match, the block first sends out, oldest first, every store up to and including the youngest match, and only then sends the read packet. A full buffer makes a new store wait until the oldest entry has been sent. A fence sends out the whole buffer and is then acknowledged. Every packet is held back by a pseudo-random number of idle cycles, so that traffic from several cores meets the interconnect in varying interleavings.

Top module: `tso_wbuf`

## Requirements
- R1: A write (`req_op` 2'b00) presented while the buffer has a free slot is accepted (`req_ready` high) in the same cycle and produces no packet.
- R2: A read (`req_op` 2'b01) whose address matches no buffered entry produces exactly one packet with `pkt_is_read` 1, `pkt_addr` equal to the read address and `pkt_data` 0; the read is accepted in the cycle that packet is taken.
- R3: A read whose address matches buffered entries first sends, as write packets (`pkt_is_read` 0), every entry from the oldest up to and including the youngest match, then its read packet; younger entries stay in the buffer.
- R4: Write packets always leave in the order their writes were accepted, carrying the accepted address and data.
- R5: A write presented to a full buffer is held off until the oldest entry has been sent as a write packet, and is accepted after that.
- R6: Before every packet the output stays idle for at least 1 and at most 2^GAP_W cycles, the length taken from a 16-bit linear feedback shift register with a nonzero seed.
- R7: A fence (`req_op` 2'b10, and the reserved code 2'b11 treated the same) sends every buffered entry in order and is accepted only once the buffer is empty; it emits no read packet.
- R8: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_is_read`, `pkt_addr` and `pkt_data` hold their values.
- R9: After reset the buffer is empty and `pkt_valid` is low, so a fence is accepted in its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present; held with its fields until accepted |
| req_op | input | 2 | 00 write, 01 read, 10 or 11 fence |
| req_addr | input | AW | Request address |
| req_data | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| pkt_valid | output | 1 | Packet offered to the interconnect |
| pkt_ready | input | 1 | Interconnect takes the packet this cycle |
| pkt_is_read | output | 1 | 1 read packet, 0 write packet |
| pkt_addr | output | AW | Packet address |
| pkt_data | output | DW | Packet data (0 for reads) |

## Verification
The bench builds the block with DEPTH 4 and GAP_W 2, so a handful of writes fills the buffer and the full-stall path is hit again and again in the random phase, while the idle window before a packet stays between 1 and 4 cycles and every value in it is seen. Addresses are drawn from a small set so that reads with several matching entries, where the drain must stop at the youngest match, come up often. The interconnect ready follows a fixed stuttering pattern so packets are held under backpressure at every stage of a drain.

// File: rtl/tsob_pkg.sv
package tsob_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_FENCE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_WAIT = 2'b01,
        PH_SEND = 2'b10
    } phase_e;

endpackage

// File: rtl/tsob_lfsr.sv
module tsob_lfsr #(
    parameter logic [15:0] SEED  = 16'hB5C3,
    parameter int          OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] value
);

    typedef struct packed {
        logic [15:0] sr;
    } lfsr_t;

    lfsr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            s_d.sr = {s_q.sr[14:0], s_q.sr[15] ^ s_q.sr[13] ^ s_q.sr[12] ^ s_q.sr[10]};
        end
        value = s_q.sr[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sr <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: the generator never falls into the all-zero lock-up state
    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sr != 16'h0000);

endmodule

// File: rtl/tsob_ring.sv
module tsob_ring #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          hit,
    output logic [CW-1:0] hit_len
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [CW-1:0] count;
    } ring_t;

    ring_t         r_d, r_q;
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [PW-1:0] tail;

    function automatic logic [PW-1:0] wrap_idx(input logic [PW-1:0] base, input logic [CW-1:0] off);
        logic [PW+CW:0] sum;
        sum = (PW+CW+1)'(base) + (PW+CW+1)'(off);
        if (sum >= (PW+CW+1)'(DEPTH)) begin
            sum = sum - (PW+CW+1)'(DEPTH);
        end
        return sum[PW-1:0];
    endfunction

    always_comb begin
        r_d   = r_q;
        tail  = wrap_idx(r_q.head, r_q.count);
        full  = (r_q.count == CW'(DEPTH));
        empty = (r_q.count == '0);
        count = r_q.count;
        head_addr = addr_mem[r_q.head];
        head_data = data_mem[r_q.head];

        hit     = 1'b0;
        hit_len = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < r_q.count) && (addr_mem[wrap_idx(r_q.head, CW'(i))] == look_addr)) begin
                hit     = 1'b1;
                hit_len = CW'(i + 1);
            end
        end

        if (pop) begin
            r_d.head = wrap_idx(r_q.head, CW'(1));
        end
        case ({push, pop})
            2'b10:   r_d.count = r_q.count + CW'(1);
            2'b01:   r_d.count = r_q.count - CW'(1);
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail] <= push_addr;
            data_mem[tail] <= push_data;
        end
    end

    // R5: a store is never written into a full buffer
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (r_q.count != CW'(DEPTH)));

    // R4: an entry is only sent out when one exists
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (r_q.count != '0));

    // R1: an absorbed write grows the buffer by exactly one
    p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (r_q.count == $past(r_q.count) + CW'(1)));

endmodule

// File: rtl/tsob_gap.sv
module tsob_gap #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             need,
    input  logic [GAP_W-1:0] rnd,
    input  logic             done,
    output logic             step_rnd,
    output logic             send,
    output logic             idle
);

    import tsob_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [GAP_W-1:0] wait_cnt;
    } gap_t;

    gap_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        step_rnd = 1'b0;
        unique case (g_q.phase)
            PH_IDLE: begin
                if (need) begin
                    step_rnd = 1'b1;
                    if (rnd == '0) begin
                        g_d.phase = PH_SEND;
                    end else begin
                        g_d.phase    = PH_WAIT;
                        g_d.wait_cnt = rnd;
                    end
                end
            end
            PH_WAIT: begin
                g_d.wait_cnt = g_q.wait_cnt - GAP_W'(1);
                if (g_q.wait_cnt == GAP_W'(1)) begin
                    g_d.phase = PH_SEND;
                end
            end
            PH_SEND: begin
                if (done) begin
                    g_d.phase = PH_IDLE;
                end
            end
            default: g_d.phase = PH_IDLE;
        endcase
        send = (g_q.phase == PH_SEND);
        idle = (g_q.phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.phase    <= PH_IDLE;
            g_q.wait_cnt <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    // R6: a wait phase always has cycles left to count
    p_wait_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.phase == PH_WAIT) |-> (g_q.wait_cnt != '0));

    // R6: a taken packet is followed by at least one idle cycle
    p_idle_after_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && done) |=> !send);

    // R8: an offered packet stays offered until taken
    p_send_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !done) |=> send);

endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
    parameter int          DEPTH = 8,
    parameter int          AW    = 32,
    parameter int          DW    = 32,
    parameter int          GAP_W = 3,
    parameter logic [15:0] SEED  = 16'hB5C3,
    localparam int         CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          pkt_valid,
    input  logic          pkt_ready,
    output logic          pkt_is_read,
    output logic [AW-1:0] pkt_addr,
    output logic [DW-1:0] pkt_data
);

    import tsob_pkg::*;

    logic             push, pop;
    logic [AW-1:0]    head_addr;
    logic [DW-1:0]    head_data;
    logic [CW-1:0]    count, hit_len, pending;
    logic             full, empty, hit;
    logic             need_wr, need_rd, take;
    logic             step_rnd, send, gap_idle;
    logic [GAP_W-1:0] rnd;
    op_e              op;

    tsob_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_data),
        .pop       (pop),
        .look_addr (req_addr),
        .head_addr (head_addr),
        .head_data (head_data),
        .count     (count),
        .full      (full),
        .empty     (empty),
        .hit       (hit),
        .hit_len   (hit_len)
    );

    tsob_lfsr #(.SEED(SEED), .OUT_W(GAP_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_rnd),
        .value (rnd)
    );

    tsob_gap #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .need     (need_wr || need_rd),
        .rnd      (rnd),
        .done     (take),
        .step_rnd (step_rnd),
        .send     (send),
        .idle     (gap_idle)
    );

    always_comb begin
        op = op_e'(req_op);
        unique case (op)
            OP_WRITE: pending = full ? CW'(1) : '0;
            OP_READ:  pending = hit ? hit_len : '0;
            default:  pending = count;
        endcase

        need_wr = req_valid && (pending != '0);
        need_rd = req_valid && (op == OP_READ) && (pending == '0);

        pkt_valid   = send;
        pkt_is_read = need_rd;
        pkt_addr    = need_rd ? req_addr : head_addr;
        pkt_data    = need_rd ? '0 : head_data;
        take        = send && pkt_ready;
        pop         = take && !need_rd;

        unique case (op)
            OP_WRITE: req_ready = req_valid && (pending == '0);
            OP_READ:  req_ready = take && need_rd;
            default:  req_ready = req_valid && empty && gap_idle;
        endcase
        push = req_ready && (op == OP_WRITE);
    end

    // R1: an absorbed write never coincides with an outgoing packet
    p_write_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_op == 2'b00) |-> !pkt_valid);

    // R3: a read is only acknowledged together with its own read packet
    p_read_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_op == 2'b01) |-> (pkt_valid && pkt_is_read && pkt_addr == req_addr));

    // R7: a fence is acknowledged only with nothing left buffered
    p_fence_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_op[1]) |-> (count == '0));

    // R8: packet fields hold under backpressure
    p_pkt_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_is_read)
                                       && $stable(pkt_addr) && $stable(pkt_data)));

endmodule

// File: tb/tso_wbuf_bench.sv
module tso_wbuf_bench;

    localparam int DEPTH = 4;
    localparam int GAP_W = 2;
    localparam int MAXIDLE = 1 << GAP_W;

    typedef struct packed {
        logic        rd;
        logic [31:0] addr;
        logic [31:0] data;
    } pkt_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_ready;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic        pkt_is_read;
    logic [31:0] pkt_addr;
    logic [31:0] pkt_data;

    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   done_flag = 1'b0;

    pkt_t        exp_q[$];
    logic [31:0] m_addr[$];
    logic [31:0] m_data[$];

    tso_wbuf #(.DEPTH(DEPTH), .AW(32), .DW(32), .GAP_W(GAP_W)) u_tso_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .req_ready   (req_ready),
        .pkt_valid   (pkt_valid),
        .pkt_ready   (pkt_ready),
        .pkt_is_read (pkt_is_read),
        .pkt_addr    (pkt_addr),
        .pkt_data    (pkt_data)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stuttering interconnect ready
    always @(negedge clk) begin
        cyc <= cyc + 1;
        pkt_ready <= (cyc % 5 != 1) && (cyc % 7 != 3);
    end

    // monitor / scoreboard
    initial begin
        int   run = 0;
        bit   prev_v = 0, prev_hold = 0;
        pkt_t held = '0;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (pkt_valid) begin
                    if (prev_hold) begin
                        check({pkt_is_read, pkt_addr, pkt_data} == held, "R8",
                              "held packet changed", {32'h0, pkt_addr}, {32'h0, held.addr});
                    end
                    if (!prev_v) begin
                        check(run >= 1 && run <= MAXIDLE, "R6", "idle cycles before packet",
                              64'(run), 64'(MAXIDLE));
                        run = 0;
                    end
                    if (pkt_ready) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R1", "unexpected packet", {32'h0, pkt_addr}, 64'h0);
                        end else begin
                            pkt_t e;
                            e = exp_q.pop_front();
                            check(pkt_is_read == e.rd, e.rd ? "R2" : "R4", "packet kind",
                                  64'(pkt_is_read), 64'(e.rd));
                            check(pkt_addr == e.addr && pkt_data == e.data, e.rd ? "R3" : "R4",
                                  "packet addr/data", {pkt_addr, pkt_data}, {e.addr, e.data});
                        end
                    end
                end else if (exp_q.size() > 0) begin
                    run++;
                end else begin
                    run = 0;
                end
                prev_hold = pkt_valid && !pkt_ready;
                held = {pkt_is_read, pkt_addr, pkt_data};
                prev_v = pkt_valid;
            end
        end
    end

    // driver: updates the bench's own buffer model and the expected queue
    task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data);
        int  lat = 0;
        bit  was_full = 0;
        bit  r = 0;
        @(negedge clk);
        if (op == 2'b00) begin
            if (m_addr.size() == DEPTH) begin
                was_full = 1;
                exp_q.push_back({1'b0, m_addr.pop_front(), m_data.pop_front()});
            end
        end else if (op == 2'b01) begin
            int j = -1;
            foreach (m_addr[i]) if (m_addr[i] == addr) j = i;
            for (int k = 0; k <= j; k++) begin
                exp_q.push_back({1'b0, m_addr.pop_front(), m_data.pop_front()});
            end
            exp_q.push_back({1'b1, addr, 32'h0});
        end else begin
            while (m_addr.size() > 0) begin
                exp_q.push_back({1'b0, m_addr.pop_front(), m_data.pop_front()});
            end
        end
        req_valid = 1'b1;
        req_op = op;
        req_addr = addr;
        req_data = data;
        forever begin
            #3;
            r = req_ready;
            lat++;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        #1 req_valid = 1'b0;
        if (op == 2'b00) begin
            m_addr.push_back(addr);
            m_data.push_back(data);
            if (was_full) check(lat > 1, "R5", "write to full buffer not held off", 64'(lat), 64'd2);
            else          check(lat == 1, "R1", "write with free slot latency", 64'(lat), 64'd1);
        end else if (op == 2'b01) begin
            check(exp_q.size() == 0, "R3", "read acknowledged before its drain", 64'(exp_q.size()), 64'd0);
        end else begin
            check(exp_q.size() == 0, "R7", "fence acknowledged with stores left", 64'(exp_q.size()), 64'd0);
        end
    endtask

    task automatic quiet_check(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #3;
            if (pkt_valid) seen = 1;
        end
        check(!seen, req, "packet while only writes buffered", 64'(seen), 64'd0);
    endtask

    initial begin
        logic [15:0] s = 16'h1D2F;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R9: reset state
        check(pkt_valid == 1'b0, "R9", "pkt_valid after reset", 64'(pkt_valid), 64'd0);
        req_valid = 1'b1;
        req_op = 2'b10;
        #1;
        check(req_ready == 1'b1, "R9", "fence on empty buffer ready at once", 64'(req_ready), 64'd1);
        @(posedge clk);
        #1 req_valid = 1'b0;

        // R1: writes are absorbed silently
        do_req(2'b00, 32'h100, 32'hA1);
        do_req(2'b00, 32'h200, 32'hA2);
        do_req(2'b00, 32'h300, 32'hA3);
        quiet_check(12, "R1");

        // R2: read miss
        do_req(2'b01, 32'h999, 32'h0);
        // R3: read hit on the middle entry drains the two oldest
        do_req(2'b01, 32'h200, 32'h0);
        quiet_check(8, "R3");
        // R3: several matches, drain stops at the youngest
        do_req(2'b00, 32'h300, 32'hB3);
        do_req(2'b00, 32'h400, 32'hB4);
        do_req(2'b01, 32'h300, 32'h0);
        // R5: fill and overflow
        for (int i = 0; i < 6; i++) do_req(2'b00, 32'h500 + 32'(i), 32'hC0 + 32'(i));
        // R7: fence drains everything, reserved code also fences
        do_req(2'b10, 32'h0, 32'h0);
        do_req(2'b00, 32'h600, 32'hD0);
        do_req(2'b11, 32'h0, 32'h0);

        // mixed traffic on a small address set
        for (int n = 0; n < 300; n++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            if (s[3:0] < 4'd9)       do_req(2'b00, 32'h40 + 32'(s[6:5]), 32'(s) ^ 32'(n));
            else if (s[3:0] < 4'd15) do_req(2'b01, 32'h40 + 32'(s[8:7]), 32'h0);
            else                     do_req(2'b10, 32'h0, 32'h0);
        end
        do_req(2'b10, 32'h0, 32'h0);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", "expected packets left over", 64'(exp_q.size()), 64'd0);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule